// File: doc/BRIEF.md
# Interrupt Vector Cache with Conditional End-of-Interrupt

This block keeps a four-way, fully associative cache of per-source interrupt state in front of a backing table of per-source entries. Each entry holds a pending flag and a two-bit generation count. When an interrupt arrives for a source, the block looks it up in the cache. On a miss it allocates a way in round-robin order, writes the evicted entry back to the table, loads the new entry from the table and marks it pending. A one-cycle delivery pulse is raised whenever the pending flag goes from clear to set.

Software finishes an interrupt with an update command. The command names a source and can clear the pending flag, replace the generation count, or both. It can also ask that the change happen only when the cached generation equals an expected value. Software advances the generation in the table first, through the table write port, and only then issues the conditional update. If the entry was reloaded in between, the reload carries the newer generation, so the stale clear is refused and the new interrupt stays pending. A read port returns the coherent state of any source: the cached copy when the source is cached, otherwise the table copy.

Top module: `ivec_cache`

## Requirements
- R1: An entry is three bits: bit 0 is the pending flag P and bits 2:1 are the generation. The table write port and the read port both use this layout.
- R2: After reset every way is invalid, every table entry is zero and the delivery output is low.
- R3: An update for a cached source with the conditional bit clear clears P when its P-enable is set. When its generation-enable is set, it replaces the generation with the new-generation field.
- R4: An update for a cached source with the conditional bit set, whose expected generation differs from the cached one, leaves P and the generation unchanged.
- R5: An update with the conditional bit set and a matching expected generation applies its enabled changes as in R3.
- R6: An update for a source that is not cached has no effect and allocates no way.
- R7: An interrupt for an uncached source loads the entry from the table with P set and the table's generation. Delivery is signalled only if the table's P was clear.
- R8: An interrupt for a cached source whose P is set changes nothing. When P is clear, the interrupt sets P and drives deliverValid high for one cycle, one cycle later, with deliverSrc equal to the source.
- R9: Allocation picks ways in round-robin order starting at way 0. A valid victim is written back to the table with its state after any same-cycle update, and no two valid ways hold the same source.
- R10: When an update and an interrupt target the same source in one cycle, the update is applied first and the interrupt after it, so P ends set.
- R11: After software writes a newer generation to the table of an evicted source, a reload carries that generation and a conditional clear expecting the older generation is refused.
- R12: A software table write and a victim write-back to the same source in the same cycle leave the software value in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqValid | input | 1 | Incoming interrupt strobe |
| irqSrc | input | SRC_W | Source of the incoming interrupt |
| updValid | input | 1 | Update command strobe |
| updSrc | input | SRC_W | Source named by the update |
| updEnP | input | 1 | Update clears P |
| updEnGen | input | 1 | Update replaces the generation |
| updCond | input | 1 | Apply the update only on a generation match |
| updGenMatch | input | 2 | Expected generation |
| updGenNew | input | 2 | New generation value |
| tblWr | input | 1 | Software table write strobe |
| tblWrSrc | input | SRC_W | Table entry to write |
| tblWrData | input | 3 | Entry value, layout per R1 |
| deliverValid | output | 1 | One-cycle delivery pulse |
| deliverSrc | output | SRC_W | Source being delivered |
| rdSrc | input | SRC_W | Source to inspect |
| rdCached | output | 1 | Inspected source is cached |
| rdP | output | 1 | Pending flag of the inspected source |
| rdGen | output | 2 | Generation of the inspected source |

## Verification
An end-of-interrupt update and a new interrupt can land on the same source in the same cycle. The result is only correct if the clear is applied before the set. The bench provokes this directly, by driving an unconditional clear together with an interrupt on a pending cached source, and randomly, by issuing both strobes with sources drawn from a small pool. It judges the result by the delivery pulse in the next cycle and by the pending flag shown on the read port, which must be set. The same collision is checked against a write-back, where a software table write and an eviction hit one entry.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int IVC_WAYS = 4;
  localparam int WAY_W = $clog2(IVC_WAYS);
  localparam int GEN_W = 2;

  typedef struct packed {
    logic [GEN_W-1:0] gen;
    logic             p;
  } ivcEntry_t;

  typedef struct packed {
    logic             updWrite;
    logic             updClrP;
    logic             updSetGen;
    logic [GEN_W-1:0] updGen;
    logic [WAY_W-1:0] updWay;
    logic             irqSetP;
    logic [WAY_W-1:0] irqWay;
    logic             alloc;
    logic             deliver;
  } ivcStrobe_t;
endpackage

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic                             irqValid,
  input  logic [SRC_W-1:0]                 irqSrc,
  input  logic                             updValid,
  input  logic [SRC_W-1:0]                 updSrc,
  input  logic                             updEnP,
  input  logic                             updEnGen,
  input  logic                             updCond,
  input  logic [GEN_W-1:0]                 updGenMatch,
  input  logic [GEN_W-1:0]                 updGenNew,
  input  logic [IVC_WAYS-1:0]              wayValid,
  input  logic [IVC_WAYS-1:0][SRC_W-1:0]   wayTag,
  input  ivcEntry_t [IVC_WAYS-1:0]         wayEnt,
  input  ivcEntry_t                        tblEntIrq,
  output ivcStrobe_t                       strb
);
  logic             updHit, irqHit, updPass, pAfter;
  logic [WAY_W-1:0] updWay, irqWay;

  always_comb begin
    updHit = 1'b0;
    irqHit = 1'b0;
    updWay = '0;
    irqWay = '0;
    for (int w = 0; w < IVC_WAYS; w++) begin
      if (wayValid[w] && wayTag[w] == updSrc) begin
        updHit = 1'b1;
        updWay = WAY_W'(w);
      end
      if (wayValid[w] && wayTag[w] == irqSrc) begin
        irqHit = 1'b1;
        irqWay = WAY_W'(w);
      end
    end
  end

  always_comb begin
    updPass = !updCond || (wayEnt[updWay].gen == updGenMatch);
    strb = '0;
    strb.updWrite  = updValid && updHit && updPass;
    strb.updClrP   = updEnP;
    strb.updSetGen = updEnGen;
    strb.updGen    = updGenNew;
    strb.updWay    = updWay;
    // the update lands first; the interrupt sees its result
    pAfter = wayEnt[irqWay].p;
    if (strb.updWrite && updEnP && updWay == irqWay) pAfter = 1'b0;
    strb.irqWay  = irqWay;
    strb.irqSetP = irqValid && irqHit && !pAfter;
    strb.alloc   = irqValid && !irqHit;
    strb.deliver = strb.irqSetP || (strb.alloc && !tblEntIrq.p);
  end
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ivcStrobe_t                       strb,
  input  logic [SRC_W-1:0]                 irqSrc,
  input  logic                             tblWr,
  input  logic [SRC_W-1:0]                 tblWrSrc,
  input  ivcEntry_t                        tblWrData,
  input  logic [SRC_W-1:0]                 rdSrc,
  output logic [IVC_WAYS-1:0]              wayValid,
  output logic [IVC_WAYS-1:0][SRC_W-1:0]   wayTag,
  output ivcEntry_t [IVC_WAYS-1:0]         wayEnt,
  output ivcEntry_t                        tblEntIrq,
  output logic                             deliverValid,
  output logic [SRC_W-1:0]                 deliverSrc,
  output logic                             rdCached,
  output ivcEntry_t                        rdEnt
);
  localparam int NUM_SRC = 1 << SRC_W;

  ivcEntry_t                tbl [NUM_SRC];
  ivcEntry_t [IVC_WAYS-1:0] entUpd;
  logic [WAY_W-1:0]         rrPtr;

  assign tblEntIrq = tbl[irqSrc];

  always_comb begin
    entUpd = wayEnt;
    if (strb.updWrite) begin
      if (strb.updClrP)   entUpd[strb.updWay].p   = 1'b0;
      if (strb.updSetGen) entUpd[strb.updWay].gen = strb.updGen;
    end
  end

  always_comb begin
    rdCached = 1'b0;
    rdEnt    = tbl[rdSrc];
    for (int w = 0; w < IVC_WAYS; w++) begin
      if (wayValid[w] && wayTag[w] == rdSrc) begin
        rdCached = 1'b1;
        rdEnt    = wayEnt[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wayValid     <= '0;
      wayTag       <= '0;
      wayEnt       <= '0;
      rrPtr        <= '0;
      deliverValid <= 1'b0;
      deliverSrc   <= '0;
      for (int s = 0; s < NUM_SRC; s++) tbl[s] <= '0;
    end else begin
      wayEnt <= entUpd;
      if (strb.irqSetP) wayEnt[strb.irqWay].p <= 1'b1;
      if (strb.alloc) begin
        if (wayValid[rrPtr]) tbl[wayTag[rrPtr]] <= entUpd[rrPtr];
        wayValid[rrPtr] <= 1'b1;
        wayTag[rrPtr]   <= irqSrc;
        wayEnt[rrPtr]   <= '{gen: tblEntIrq.gen, p: 1'b1};
        rrPtr <= (rrPtr == WAY_W'(IVC_WAYS - 1)) ? '0 : rrPtr + 1'b1;
      end
      // software write is placed last so it wins over a write-back
      if (tblWr) tbl[tblWrSrc] <= tblWrData;
      deliverValid <= strb.deliver;
      deliverSrc   <= irqSrc;
    end
  end
endmodule

// File: rtl/ivec_cache.sv
module ivec_cache
  import ivc_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqValid,
  input  logic [SRC_W-1:0] irqSrc,
  input  logic             updValid,
  input  logic [SRC_W-1:0] updSrc,
  input  logic             updEnP,
  input  logic             updEnGen,
  input  logic             updCond,
  input  logic [1:0]       updGenMatch,
  input  logic [1:0]       updGenNew,
  input  logic             tblWr,
  input  logic [SRC_W-1:0] tblWrSrc,
  input  logic [2:0]       tblWrData,
  output logic             deliverValid,
  output logic [SRC_W-1:0] deliverSrc,
  input  logic [SRC_W-1:0] rdSrc,
  output logic             rdCached,
  output logic             rdP,
  output logic [1:0]       rdGen
);
  ivcStrobe_t                     strb;
  logic [IVC_WAYS-1:0]            wayValid;
  logic [IVC_WAYS-1:0][SRC_W-1:0] wayTag;
  ivcEntry_t [IVC_WAYS-1:0]       wayEnt;
  ivcEntry_t                      tblEntIrq;
  ivcEntry_t                      rdEnt;

  ivc_ctrl #(.SRC_W(SRC_W)) u_ctrl (
    .irqValid(irqValid), .irqSrc(irqSrc),
    .updValid(updValid), .updSrc(updSrc), .updEnP(updEnP), .updEnGen(updEnGen),
    .updCond(updCond), .updGenMatch(updGenMatch), .updGenNew(updGenNew),
    .wayValid(wayValid), .wayTag(wayTag), .wayEnt(wayEnt),
    .tblEntIrq(tblEntIrq), .strb(strb)
  );

  ivc_datapath #(.SRC_W(SRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqSrc(irqSrc),
    .tblWr(tblWr), .tblWrSrc(tblWrSrc), .tblWrData(ivcEntry_t'(tblWrData)),
    .rdSrc(rdSrc), .wayValid(wayValid), .wayTag(wayTag), .wayEnt(wayEnt),
    .tblEntIrq(tblEntIrq), .deliverValid(deliverValid), .deliverSrc(deliverSrc),
    .rdCached(rdCached), .rdEnt(rdEnt)
  );

  assign rdP   = rdEnt.p;
  assign rdGen = rdEnt.gen;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           irqValid,
  input logic [SRC_W-1:0]               irqSrc,
  input logic                           updValid,
  input logic [SRC_W-1:0]               updSrc,
  input logic                           updCond,
  input logic [1:0]                     updGenMatch,
  input logic                           deliverValid,
  input logic [SRC_W-1:0]               deliverSrc,
  input logic [IVC_WAYS-1:0]            wayValid,
  input logic [IVC_WAYS-1:0][SRC_W-1:0] wayTag,
  input ivcEntry_t [IVC_WAYS-1:0]       wayEnt
);
  logic             prevIrq, mmPend;
  logic [SRC_W-1:0] prevIrqSrc, mmSrc;
  ivcEntry_t        mmEnt, updEntNow, irqLkEnt, mmLkEnt;
  logic             updHit, irqLkHit, mmLkHit, dupTag;

  always_comb begin
    updHit = 1'b0; updEntNow = '0;
    irqLkHit = 1'b0; irqLkEnt = '0;
    mmLkHit = 1'b0; mmLkEnt = '0;
    dupTag = 1'b0;
    for (int w = 0; w < IVC_WAYS; w++) begin
      if (wayValid[w] && wayTag[w] == updSrc) begin updHit = 1'b1; updEntNow = wayEnt[w]; end
      if (wayValid[w] && wayTag[w] == prevIrqSrc) begin irqLkHit = 1'b1; irqLkEnt = wayEnt[w]; end
      if (wayValid[w] && wayTag[w] == mmSrc) begin mmLkHit = 1'b1; mmLkEnt = wayEnt[w]; end
      for (int v = w + 1; v < IVC_WAYS; v++)
        if (wayValid[w] && wayValid[v] && wayTag[w] == wayTag[v]) dupTag = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIrq <= 1'b0; prevIrqSrc <= '0;
      mmPend <= 1'b0; mmSrc <= '0; mmEnt <= '0;
    end else begin
      prevIrq    <= irqValid;
      prevIrqSrc <= irqSrc;
      mmPend     <= updValid && !irqValid && updCond && updHit && (updEntNow.gen != updGenMatch);
      mmSrc      <= updSrc;
      mmEnt      <= updEntNow;
    end
  end

  assert_deliver_origin_R8: assert property (@(posedge clk) disable iff (!rstN)
    deliverValid |-> (prevIrq && deliverSrc == prevIrqSrc));

  assert_irq_leaves_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    prevIrq |-> (irqLkHit && irqLkEnt.p));

  assert_cond_reject_R4: assert property (@(posedge clk) disable iff (!rstN)
    mmPend |-> (mmLkHit && mmLkEnt == mmEnt));

  assert_unique_tags_R9: assert property (@(posedge clk) disable iff (!rstN) !dupTag);

  assert_miss_update_no_alloc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !irqValid && !updHit) |=> $stable(wayValid));
endmodule

bind ivec_cache ivc_checker #(.SRC_W(SRC_W)) u_ivc_checker (
  .clk(clk), .rstN(rstN), .irqValid(irqValid), .irqSrc(irqSrc),
  .updValid(updValid), .updSrc(updSrc), .updCond(updCond), .updGenMatch(updGenMatch),
  .deliverValid(deliverValid), .deliverSrc(deliverSrc),
  .wayValid(wayValid), .wayTag(wayTag), .wayEnt(wayEnt)
);

// File: tb/test_ivec_cache.sv
`timescale 1ns/100ps
module test_ivec_cache;
  localparam int SW = 4;
  localparam int NS = 1 << SW;

  logic clk = 1'b0, rstN = 1'b0;
  logic irqValid = 0, updValid = 0, updEnP = 0, updEnGen = 0, updCond = 0, tblWr = 0;
  logic [SW-1:0] irqSrc = 0, updSrc = 0, tblWrSrc = 0, rdSrc = 0;
  logic [1:0] updGenMatch = 0, updGenNew = 0;
  logic [2:0] tblWrData = 0;
  logic deliverValid, rdCached, rdP;
  logic [SW-1:0] deliverSrc;
  logic [1:0] rdGen;

  int nTests = 0, nFail = 0;
  bit done = 0;

  bit [2:0] mTbl [NS];
  bit       mValid [4];
  bit [SW-1:0] mTag [4];
  bit       mP [4];
  bit [1:0] mGen [4];
  int       mRr;
  bit       expDlv;
  bit [SW-1:0] expSrc;

  ivec_cache #(.SRC_W(SW)) i_ivec_cache (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit [3:0] mRead(input bit [SW-1:0] s);
    bit [3:0] r = {1'b0, mTbl[s]};
    for (int w = 0; w < 4; w++)
      if (mValid[w] && mTag[w] == s) r = {1'b1, mGen[w], mP[w]};
    return r;
  endfunction

  task automatic modelStep();
    int uw = -1, iw = -1;
    bit [2:0] t;
    for (int w = 0; w < 4; w++) begin
      if (mValid[w] && mTag[w] == updSrc) uw = w;
      if (mValid[w] && mTag[w] == irqSrc) iw = w;
    end
    if (updValid && uw >= 0 && (!updCond || mGen[uw] == updGenMatch)) begin
      if (updEnP) mP[uw] = 0;
      if (updEnGen) mGen[uw] = updGenNew;
    end
    expDlv = 0;
    expSrc = irqSrc;
    if (irqValid) begin
      if (iw >= 0) begin
        if (!mP[iw]) begin mP[iw] = 1; expDlv = 1; end
      end else begin
        t = mTbl[irqSrc];
        if (mValid[mRr]) mTbl[mTag[mRr]] = {mGen[mRr], mP[mRr]};
        mValid[mRr] = 1; mTag[mRr] = irqSrc; mP[mRr] = 1; mGen[mRr] = t[2:1];
        expDlv = !t[0];
        mRr = (mRr + 1) % 4;
      end
    end
    if (tblWr) mTbl[tblWrSrc] = tblWrData;
  endtask

  // one clock with the currently driven inputs, then model compare
  task automatic step();
    bit [3:0] got, want;
    bit bad = 0;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    irqValid = 0; updValid = 0; tblWr = 0;
    chk(deliverValid == expDlv, "R8 deliver pulse", deliverValid, expDlv);
    if (expDlv) chk(deliverSrc == expSrc, "R8 deliver source", deliverSrc, expSrc);
    for (int s = 0; s < NS; s++) begin
      rdSrc = SW'(s);
      #0.2;
      got = {rdCached, rdGen, rdP};
      want = mRead(SW'(s));
      if (got != want && !bad) begin
        bad = 1;
        chk(0, "R9 state sweep", got, want);
      end
    end
    if (!bad) chk(1, "R9 state sweep", 0, 0);
  endtask

  task automatic expectRd(input int s, input bit c, input bit p, input int g, input string req);
    rdSrc = SW'(s);
    #0.2;
    chk({rdCached, rdP, rdGen} == {c, p, 2'(g)}, req, {rdCached, rdP, rdGen}, {c, p, 2'(g)});
  endtask

  task automatic irq(input int s);
    irqValid = 1; irqSrc = SW'(s);
  endtask

  task automatic upd(input int s, input bit enP, input bit enG, input bit cond, input int m, input int n);
    updValid = 1; updSrc = SW'(s); updEnP = enP; updEnGen = enG; updCond = cond;
    updGenMatch = 2'(m); updGenNew = 2'(n);
  endtask

  task automatic twr(input int s, input int d);
    tblWr = 1; tblWrSrc = SW'(s); tblWrData = 3'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < NS; s++) mTbl[s] = 0;
    for (int w = 0; w < 4; w++) begin mValid[w] = 0; mTag[w] = 0; mP[w] = 0; mGen[w] = 0; end
    mRr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R2 reset state
    chk(deliverValid == 0, "R2 deliver after reset", deliverValid, 0);
    for (int s = 0; s < NS; s++) expectRd(s, 0, 0, 0, "R2 reset entry");
    // R1 layout: gen 2, P clear
    twr(5, 3'b100); step();
    expectRd(5, 0, 0, 2, "R1 table layout");
    // R7 miss reload
    irq(5); step();
    chk(deliverValid == 1, "R7 deliver on reload", deliverValid, 1);
    expectRd(5, 1, 1, 2, "R7 reload state");
    // R8 pending already set
    irq(5); step();
    chk(deliverValid == 0, "R8 no redeliver", deliverValid, 0);
    // R4 mismatch rejected
    upd(5, 1, 1, 1, 3, 3); step();
    expectRd(5, 1, 1, 2, "R4 mismatch keeps entry");
    // R5 match applies
    upd(5, 1, 1, 1, 2, 3); step();
    expectRd(5, 1, 0, 3, "R5 match applies");
    irq(5); step();
    chk(deliverValid == 1 && deliverSrc == 5, "R8 deliver after clear", deliverSrc, 5);
    // R3 unconditional P clear only
    upd(5, 1, 0, 0, 0, 1); step();
    expectRd(5, 1, 0, 3, "R3 unconditional clear");
    // R6 uncached update ignored
    upd(9, 1, 1, 0, 0, 2); step();
    expectRd(9, 0, 0, 0, "R6 uncached untouched");
    // R10 same-cycle update and interrupt
    irq(5); step();
    upd(5, 1, 0, 0, 0, 0); irq(5); step();
    chk(deliverValid == 1, "R10 deliver on collision", deliverValid, 1);
    expectRd(5, 1, 1, 3, "R10 pending ends set");
    // R9 eviction of source 5 (way 0) after four allocations
    irq(1); step(); irq(2); step(); irq(3); step(); irq(4); step();
    expectRd(5, 0, 1, 3, "R9 write-back of victim");
    // R11 race: software advances generation, reload, stale clear
    twr(5, 3'b000); step();
    irq(5); step();
    chk(deliverValid == 1, "R11 reload delivers", deliverValid, 1);
    expectRd(5, 1, 1, 0, "R11 reload carries new gen");
    upd(5, 1, 1, 1, 3, 0); step();
    expectRd(5, 1, 1, 0, "R11 stale clear refused");
    // R12 software write beats write-back (next victim is source 2)
    irq(6); twr(2, 3'b110); step();
    expectRd(2, 0, 0, 3, "R12 software write wins");
    // random mix over a small source pool
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 1)) irq($urandom_range(0, 7));
      if ($urandom_range(0, 1))
        upd($urandom_range(0, 7), 1'($urandom), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) twr($urandom_range(0, 7), $urandom_range(0, 7));
      step();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule